// File: doc/BRIEF.md
# GPIO Level-Mismatch Interrupt Controller

This block watches eight input pins, grouped as two ports of four. For each pin it holds an "old value" bit that software owns. A pin is pending whenever its synchronized level differs from its old value. A pending bit stays set until software acknowledges that pin. Software acknowledges by issuing a set-old or clear-old command. The command moves the old value to the level software now expects and clears the pending bit. When a bit is pending, its old value tells which edge caused it. An old value of 0 means the pin went from low to high. An old value of 1 means the pin went from high to low.

Commands arrive on two paths. One is a 32-bit status/command word on a small register bus. The other is a pin-addressed acknowledge port. The acknowledge port names a logical port and a pin number, and the block maps that logical port to a physical port before applying the command. An 8-bit enable register selects which pending pins drive the single interrupt request to the host.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the old values, the pending bits, the enable register and `irq` are all 0.
- R2: A read at `bus_addr`=0 returns the pending bits in [7:0] and the old values in [15:8]; bits [31:16] read as 0. A read at `bus_addr`=1 returns the enable register in [7:0] with zeros above it. Pin index n = port*4 + pin.
- R3: When a pin's level becomes different from its old value, the pending bit is set on the third rising clock edge after the change, because of a two-flop synchronizer. The bit stays set if the pin then returns to its old value.
- R4: A word write with bit 16+n set forces old value n to 1 and clears pending bit n on the same edge.
- R5: A word write with bit 24+n set forces old value n to 0 and clears pending bit n. If both commands are given for the same pin, the clear-old command wins.
- R6: Word writes to bits [15:0] have no effect on the old values or the pending bits.
- R7: If a pin still differs from its old value after an acknowledge, its pending bit returns to 1 on the next clock edge.
- R8: A write at `bus_addr`=1 loads the enable register, with bit n enabling pin n. `irq` is the OR of (pending AND enable) over all eight pins.
- R9: An acknowledge-port command applies to pin n = p*4 + `ack_pin`, where p = `ack_port` XOR (`swap_en` AND `strap_ovr`). `ack_set`=1 means set-old and `ack_set`=0 means clear-old. Each has the same effect as the matching word command.
- R10: An acknowledge-port command with `ack_pin` greater than 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 8 | Asynchronous pin levels, index port*4+pin |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 1 | 0 = status/command word, 1 = enable register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ack_valid | input | 1 | Pin-addressed acknowledge strobe |
| ack_port | input | 1 | Logical port of the acknowledge |
| ack_pin | input | 3 | Pin number of the acknowledge; values above 3 are invalid |
| ack_set | input | 1 | 1 = set-old, 0 = clear-old |
| swap_en | input | 1 | Port swap request |
| strap_ovr | input | 1 | Strap override; the swap takes effect only when this is also set |
| irq | output | 1 | Interrupt request to the host |

## Verification
The hardest state to reach is a pending bit that is re-raised right after an acknowledge. Reaching it needs the pin, the old value and the command to line up on one edge. The bench sets this up on purpose. It acknowledges with the command that leaves the old value different from the held pin level. It then samples once just after the acknowledge edge and once a cycle later. The swap mapping is covered by running every swap/override combination against every pin through the acknowledge port. Out-of-range pin numbers are also sent there, to confirm they have no effect.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  pin_in,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ack_valid,
  input  logic        ack_port,
  input  logic [2:0]  ack_pin,
  input  logic        ack_set,
  input  logic        swap_en,
  input  logic        strap_ovr,
  output logic        irq
);
  localparam int PER_PORT = 4;
  localparam int NPIN     = 2 * PER_PORT;
  localparam int OLD_LSB  = NPIN;
  localparam int SET_LSB  = 2 * NPIN;
  localparam int CLR_LSB  = 3 * NPIN;

  logic [NPIN-1:0] sync1, sync2, old_val, pend, enable;
  logic [NPIN-1:0] ack_hot, cmd_set, cmd_clr, cmd_any;
  logic            wr_word, wr_en, ack_ok;
  logic [2:0]      ack_idx;
  logic            unused_wbits;

  assign unused_wbits = ^bus_wdata[OLD_LSB+NPIN-1:OLD_LSB];

  assign wr_word = bus_sel & bus_wr & ~bus_addr;
  assign wr_en   = bus_sel & bus_wr &  bus_addr;

  assign ack_ok  = ack_valid && (ack_pin < 3'(PER_PORT));
  assign ack_idx = {ack_port ^ (swap_en & strap_ovr), ack_pin[1:0]};
  assign ack_hot = ack_ok ? (NPIN'(1) << ack_idx) : '0;

  assign cmd_set = (wr_word ? bus_wdata[SET_LSB +: NPIN] : '0) | (ack_set  ? ack_hot : '0);
  assign cmd_clr = (wr_word ? bus_wdata[CLR_LSB +: NPIN] : '0) | (!ack_set ? ack_hot : '0);
  assign cmd_any = cmd_set | cmd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1   <= '0;
      sync2   <= '0;
      old_val <= '0;
      pend    <= '0;
      enable  <= '0;
    end else begin
      sync1   <= pin_in;
      sync2   <= sync1;
      old_val <= (old_val | cmd_set) & ~cmd_clr;
      pend    <= (pend | (sync2 ^ old_val)) & ~cmd_any;
      if (wr_en) enable <= bus_wdata[NPIN-1:0];
    end
  end

  assign bus_rdata = bus_addr ? {24'd0, enable} : {16'd0, old_val, pend};
  assign irq       = |(pend & enable);

  AST_SET_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_set & ~cmd_clr) != '0) |=> ((old_val & $past(cmd_set & ~cmd_clr)) == $past(cmd_set & ~cmd_clr))); // R4
  AST_CLR_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr != '0) |=> ((old_val & $past(cmd_clr)) == '0)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_any != '0) |=> ((pend & $past(cmd_any)) == '0)); // R4
  AST_OLD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_any == '0) |=> $stable(old_val)); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~cmd_any) != '0) |=> ((pend & $past(pend & ~cmd_any)) == $past(pend & ~cmd_any))); // R3
  AST_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (((sync2 ^ old_val) & ~cmd_any) != '0) |=> ((pend & $past((sync2 ^ old_val) & ~cmd_any)) == $past((sync2 ^ old_val) & ~cmd_any))); // R7
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (enable == $past(bus_wdata[NPIN-1:0]))); // R8
endmodule

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 1'b0, ack_port = 1'b0, ack_set = 1'b0;
  logic [2:0]  ack_pin = '0;
  logic        swap_en = 1'b0, strap_ovr = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_old = '0;
  logic [7:0] exp_pend = '0;

  always #2 clk = ~clk;

  gpio_edge_irq uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #0.5;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0; bus_addr = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack(input logic p, input logic [2:0] n, input logic s, input logic sw, input logic so);
    @(negedge clk);
    ack_valid = 1'b1; ack_port = p; ack_pin = n; ack_set = s; swap_en = sw; strap_ovr = so;
    @(posedge clk); #0.5;
    ack_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    rd(1'b0, d);
    check(req, d, {16'd0, exp_old, exp_pend});
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check_state("R1");
    rd(1'b1, d); check("R1", d, 32'd0);
    check("R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    step();
    check_state("R1");

    for (int i = 0; i < 8; i++) begin
      pin_in[i] = 1'b1;
      step(); step();
      check_state("R3");
      step();
      exp_pend[i] = 1'b1;
      check_state("R3");

      for (int e = 0; e < 256; e++) begin
        wr(1'b1, 32'hABCD_EF00 | e);
        rd(1'b1, d); check("R2", d, 32'(e));
        check("R8", {31'd0, irq}, {31'd0, e[i]});
      end
      wr(1'b1, 32'd0);

      pin_in[i] = 1'b0;
      repeat (4) step();
      check_state("R3");

      wr(1'b0, 32'hFFFF);
      check_state("R6");

      wr(1'b0, (32'd1 << (16 + i)) | 32'h0000_FFFF);
      exp_old[i] = 1'b1; exp_pend[i] = 1'b0;
      check_state("R4");
      step();
      exp_pend[i] = 1'b1;
      check_state("R7");

      wr(1'b0, 32'd1 << (24 + i));
      exp_old[i] = 1'b0; exp_pend[i] = 1'b0;
      check_state("R5");
      repeat (3) step();
      check_state("R5");

      pin_in[i] = 1'b1;
      repeat (3) step();
      exp_pend[i] = 1'b1;
      check_state("R3");

      for (int c = 0; c < 4; c++) begin
        logic sw, so, lp;
        sw = c[0]; so = c[1];
        lp = logic'(i / 4) ^ (sw & so);
        ack(lp, 3'(i % 4), 1'b1, sw, so);
        exp_old[i] = 1'b1; exp_pend[i] = 1'b0;
        check_state("R9");
        step();
        check_state("R9");
        ack(lp, 3'(i % 4), 1'b0, sw, so);
        exp_old[i] = 1'b0; exp_pend[i] = 1'b0;
        check_state("R9");
        step();
        exp_pend[i] = 1'b1;
        check_state("R7");
      end

      for (int n = 4; n < 8; n++) begin
        ack(logic'(i / 4), 3'(n), 1'b1, 1'b0, 1'b0);
        step();
        check_state("R10");
      end

      wr(1'b0, (32'd1 << (16 + i)) | (32'd1 << (24 + i)));
      exp_old[i] = 1'b0; exp_pend[i] = 1'b0;
      check_state("R5");
      step();
      exp_pend[i] = 1'b1;
      check_state("R7");

      pin_in[i] = 1'b0;
      repeat (3) step();
      wr(1'b0, 32'd1 << (24 + i));
      exp_pend[i] = 1'b0;
      repeat (3) step();
      check_state("R5");
    end

    pin_in = 8'hFF;
    repeat (3) step();
    exp_pend = 8'hFF;
    check_state("R3");
    wr(1'b1, 32'h0000_0081);
    check("R8", {31'd0, irq}, 32'd1);
    wr(1'b0, 32'h00FF_0000);
    exp_old = 8'hFF; exp_pend = '0;
    check_state("R4");
    check("R8", {31'd0, irq}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule